// File: doc/BRIEF.md
# Authenticated Compressed-Fetch Controller

This block serves instruction-cache misses for read-only code that is kept in off-chip memory in compressed and encrypted form. The code image is cut into 128-bit chunks. Before encryption, each chunk carries its own memory address in its low 32 bits, and one or more compressed cache lines follow at bit 32 and above. On a miss, the controller uses part of the original line address to index a translation table. The table returns the address of the chunk that holds the line and the bit position where the compressed line starts inside that chunk.

If the chunk is already held in the on-chip buffer, the controller hands it to the decompressor at once, with no memory access and no decryption. Otherwise it fetches the ciphertext, passes it to an external block-decryption unit, and waits for the plaintext. It then compares the embedded address field with the chunk address it asked for. A match fills the buffer and releases the chunk together with the start offset. A mismatch means the memory content was altered or moved. In that case the controller raises a sticky error flag, drops the buffer, and releases nothing.

The table is loaded through a write port before misses are issued. Several lines packed into one chunk share a single fetch and a single decryption.

Top module: `auth_fetch_ctrl`

## Requirements
- R1: After reset, miss_ready_o is 1 and mem_req_o, dec_start_o, line_valid_o and integrity_error_o are 0. The buffer is empty, so the first miss always fetches.
- R2: The table index is miss address bits [9:4] (16-byte lines, 64 entries). A table write at that index sets the chunk address and the 7-bit offset used by later misses, and a rewrite takes effect on the next miss.
- R3: When the translated chunk is not buffered, mem_req_o rises with mem_addr_o equal to the table's chunk address. Both stay unchanged until mem_valid_i is seen.
- R4: After the memory data arrives, dec_start_o is a one-cycle pulse with dec_data_o equal to the fetched ciphertext. There is exactly one pulse per fetch.
- R5: When dec_done_i arrives and dec_data_i[31:0] equals the chunk address, line_valid_o pulses for one cycle on the following cycle. It carries the 128-bit plaintext on line_chunk_o and the table offset on line_off_o.
- R6: When the translated chunk address equals the buffered chunk address, there is no memory request and no decryption. line_valid_o is high in the cycle right after the miss is accepted, carrying the buffered plaintext and the new entry's offset.
- R7: When dec_data_i[31:0] differs from the chunk address, integrity_error_o goes to 1, no line is delivered, and the buffer is invalidated, so a later miss to the previously buffered chunk fetches again.
- R8: miss_ready_o is 1 only while the controller is idle. A miss is accepted on a clock edge where miss_valid_i and miss_ready_o are both 1.
- R9: integrity_error_o stays 1 until reset, and later valid chunks are still delivered normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tbl_we_i | input | 1 | Translation table write enable |
| tbl_idx_i | input | 6 | Table entry index to write |
| tbl_chunk_i | input | 32 | Chunk address written to the entry |
| tbl_off_i | input | 7 | Line start bit written to the entry |
| miss_valid_i | input | 1 | Cache miss request |
| miss_addr_i | input | 32 | Original cache-line address |
| miss_ready_o | output | 1 | Controller idle, miss can be accepted |
| mem_req_o | output | 1 | Chunk read request to memory |
| mem_addr_o | output | 32 | Chunk address being read |
| mem_valid_i | input | 1 | Memory returns ciphertext this cycle |
| mem_data_i | input | 128 | Ciphertext chunk |
| dec_start_o | output | 1 | Start pulse to the decryption unit |
| dec_data_o | output | 128 | Ciphertext handed to the decryption unit |
| dec_done_i | input | 1 | Decryption result valid |
| dec_data_i | input | 128 | Plaintext chunk |
| line_valid_o | output | 1 | Chunk and offset valid for the decompressor |
| line_chunk_o | output | 128 | Verified plaintext chunk |
| line_off_o | output | 7 | Start bit of the compressed line in the chunk |
| integrity_error_o | output | 1 | Sticky tag-mismatch flag |

## Verification
The assertions assume the following about the inputs. Miss addresses are line-aligned and fall inside the 1 KB code window. The memory returns mem_valid_i only while a request is open. The decryption unit answers each start with a single dec_done_i. The bench models memory with a fixed 3-cycle response and decryption with a 17-cycle response, each raised for one cycle. It issues misses only while miss_ready_o is high and with aligned addresses in the window. The integrity failure is produced by placing a chunk whose embedded address names a different location.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DEC_GO,
    ST_DEC_WAIT,
    ST_DELIVER
  } fetch_state_e;
endpackage

// File: rtl/xlat_table.sv
module xlat_table #(
  parameter int IDX_W  = 6,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_chunk_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [ADDR_W-1:0] rd_chunk_o,
  output logic [OFF_W-1:0]  rd_off_o
);
  localparam int ENTRIES = 2 ** IDX_W;

  logic [ADDR_W-1:0] chunk_q [ENTRIES];
  logic [OFF_W-1:0]  off_q   [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chunk_q[e] <= '0;
        off_q[e]   <= '0;
      end else if (we_i && wr_idx_i == IDX_W'(e)) begin
        chunk_q[e] <= wr_chunk_i;
        off_q[e]   <= wr_off_i;
      end
    end
  end

  assign rd_chunk_o = chunk_q[rd_idx_i];
  assign rd_off_o   = off_q[rd_idx_i];
endmodule

// File: rtl/chunk_store.sv
module chunk_store #(
  parameter int ADDR_W  = 32,
  parameter int CHUNK_W = 128
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fill_i,
  input  logic [ADDR_W-1:0]  fill_addr_i,
  input  logic [CHUNK_W-1:0] fill_data_i,
  input  logic               inval_i,
  input  logic [ADDR_W-1:0]  cmp_addr_i,
  output logic               hit_o,
  output logic [CHUNK_W-1:0] data_o
);
  logic               valid_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [CHUNK_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (inval_i) begin
      valid_q <= 1'b0;
    end else if (fill_i) begin
      valid_q <= 1'b1;
      addr_q  <= fill_addr_i;
      data_q  <= fill_data_i;
    end
  end

  assign hit_o  = valid_q && (addr_q == cmp_addr_i);
  assign data_o = data_q;

  assert_inval_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i |=> !valid_q);
  assert_fill_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !inval_i) |=> (valid_q && addr_q == $past(fill_addr_i)));
endmodule

// File: rtl/auth_fetch_ctrl.sv
module auth_fetch_ctrl
  import fetch_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          LINE_BYTES = 16,
  parameter int          IDX_W      = 6,
  parameter int          CHUNK_W    = 128,
  parameter logic [31:0] CODE_BASE  = 32'h4000_0000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tbl_we_i,
  input  logic [IDX_W-1:0]   tbl_idx_i,
  input  logic [ADDR_W-1:0]  tbl_chunk_i,
  input  logic [$clog2(CHUNK_W)-1:0] tbl_off_i,
  input  logic               miss_valid_i,
  input  logic [ADDR_W-1:0]  miss_addr_i,
  output logic               miss_ready_o,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  input  logic               mem_valid_i,
  input  logic [CHUNK_W-1:0] mem_data_i,
  output logic               dec_start_o,
  output logic [CHUNK_W-1:0] dec_data_o,
  input  logic               dec_done_i,
  input  logic [CHUNK_W-1:0] dec_data_i,
  output logic               line_valid_o,
  output logic [CHUNK_W-1:0] line_chunk_o,
  output logic [$clog2(CHUNK_W)-1:0] line_off_o,
  output logic               integrity_error_o
);
  localparam int LINE_LSB = $clog2(LINE_BYTES);
  localparam int OFF_W    = $clog2(CHUNK_W);
  localparam int WIN_LSB  = LINE_LSB + IDX_W;

  fetch_state_e       state_q;
  logic [ADDR_W-1:0]  cur_chunk_q;
  logic [OFF_W-1:0]   cur_off_q;
  logic [CHUNK_W-1:0] cipher_q;
  logic               err_q;

  logic [IDX_W-1:0]   look_idx;
  logic [ADDR_W-1:0]  look_chunk;
  logic [OFF_W-1:0]   look_off;
  logic               buf_hit;
  logic               tag_ok;
  logic               dec_fin;

  assign look_idx = miss_addr_i[LINE_LSB +: IDX_W];

  xlat_table #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_xlat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (tbl_we_i),
    .wr_idx_i   (tbl_idx_i),
    .wr_chunk_i (tbl_chunk_i),
    .wr_off_i   (tbl_off_i),
    .rd_idx_i   (look_idx),
    .rd_chunk_o (look_chunk),
    .rd_off_o   (look_off)
  );

  // tag is the chunk's own address, stored in the low word
  assign tag_ok  = dec_data_i[ADDR_W-1:0] == cur_chunk_q;
  assign dec_fin = (state_q == ST_DEC_WAIT) && dec_done_i;

  chunk_store #(.ADDR_W(ADDR_W), .CHUNK_W(CHUNK_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fill_i      (dec_fin && tag_ok),
    .fill_addr_i (cur_chunk_q),
    .fill_data_i (dec_data_i),
    .inval_i     (dec_fin && !tag_ok),
    .cmp_addr_i  (look_chunk),
    .hit_o       (buf_hit),
    .data_o      (line_chunk_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cur_chunk_q <= '0;
      cur_off_q   <= '0;
      cipher_q    <= '0;
      err_q       <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (miss_valid_i) begin
          cur_chunk_q <= look_chunk;
          cur_off_q   <= look_off;
          state_q     <= buf_hit ? ST_DELIVER : ST_FETCH;
        end
        ST_FETCH: if (mem_valid_i) begin
          cipher_q <= mem_data_i;
          state_q  <= ST_DEC_GO;
        end
        ST_DEC_GO: state_q <= ST_DEC_WAIT;
        ST_DEC_WAIT: if (dec_done_i) begin
          if (tag_ok) begin
            state_q <= ST_DELIVER;
          end else begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_DELIVER: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign miss_ready_o      = state_q == ST_IDLE;
  assign mem_req_o         = state_q == ST_FETCH;
  assign mem_addr_o        = cur_chunk_q;
  assign dec_start_o       = state_q == ST_DEC_GO;
  assign dec_data_o        = cipher_q;
  assign line_valid_o      = state_q == ST_DELIVER;
  assign line_off_o        = cur_off_q;
  assign integrity_error_o = err_q;

  // input assumption: aligned misses inside the code window
  assert_in_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_i && miss_ready_o) |->
      (miss_addr_i[LINE_LSB-1:0] == '0 &&
       miss_addr_i[ADDR_W-1:WIN_LSB] == CODE_BASE[ADDR_W-1:WIN_LSB]));
  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));
  assert_start_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_start_o |=> !dec_start_o);
  assert_line_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o |=> !line_valid_o);
  assert_hit_no_fetch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_ready_o && miss_valid_i && buf_hit) |=> (line_valid_o && !mem_req_o));
  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    integrity_error_o |=> integrity_error_o);
  assert_err_no_line_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_fin && !tag_ok) |=> (!line_valid_o && integrity_error_o));
endmodule

// File: tb/auth_fetch_ctrl_bench.sv
module auth_fetch_ctrl_bench;
  localparam logic [127:0] KEY    = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;
  localparam logic [31:0]  C0     = 32'h8000_0000;
  localparam logic [31:0]  C1     = 32'h8000_0010;
  localparam logic [31:0]  CSPL   = 32'h8000_0020;
  localparam logic [31:0]  C3     = 32'h8000_0040;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic         tbl_we = 1'b0;
  logic [5:0]   tbl_idx = '0;
  logic [31:0]  tbl_chunk = '0;
  logic [6:0]   tbl_off = '0;
  logic         miss_valid = 1'b0;
  logic [31:0]  miss_addr = 32'h4000_0000;
  logic         miss_ready, mem_req, mem_valid = 1'b0;
  logic [31:0]  mem_addr;
  logic [127:0] mem_data = '0, dec_data_o, dec_out = '0, line_chunk;
  logic         dec_start, dec_done = 1'b0, line_valid, int_err;
  logic [6:0]   line_off;

  auth_fetch_ctrl u_auth_fetch_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .tbl_we_i(tbl_we), .tbl_idx_i(tbl_idx), .tbl_chunk_i(tbl_chunk), .tbl_off_i(tbl_off),
    .miss_valid_i(miss_valid), .miss_addr_i(miss_addr), .miss_ready_o(miss_ready),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_valid_i(mem_valid), .mem_data_i(mem_data),
    .dec_start_o(dec_start), .dec_data_o(dec_data_o), .dec_done_i(dec_done), .dec_data_i(dec_out),
    .line_valid_o(line_valid), .line_chunk_o(line_chunk), .line_off_o(line_off),
    .integrity_error_o(int_err)
  );

  int checks = 0;
  int errors = 0;
  int mem_reqs = 0;
  int dec_starts = 0;
  logic [31:0] last_req_addr = '0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // plaintext image; the spliced chunk carries a foreign address tag
  function automatic logic [127:0] plain_of(input logic [31:0] a);
    logic [31:0] tag;
    tag = (a == CSPL) ? a + 32'h10 : a;
    return {a ^ 32'h1357_9BDF, ~a, a + 32'h11, tag};
  endfunction

  // memory model: 3-cycle response
  bit mem_busy = 1'b0;
  int mcnt = 0;
  always @(negedge clk) begin
    if (mem_valid) mem_valid = 1'b0;
    else if (mem_req) begin
      if (!mem_busy) begin
        mem_busy = 1'b1; mcnt = 3; mem_reqs++; last_req_addr = mem_addr;
      end else if (mcnt == 1) begin
        mem_valid = 1'b1; mem_data = plain_of(last_req_addr) ^ KEY; mem_busy = 1'b0;
      end else mcnt--;
    end
  end

  // decryption model: 17-cycle response
  bit dbusy = 1'b0;
  int dcnt = 0;
  logic [127:0] dbuf = '0;
  always @(negedge clk) begin
    if (dec_done) dec_done = 1'b0;
    if (dec_start) begin
      dec_starts++; dbusy = 1'b1; dcnt = 17; dbuf = dec_data_o ^ KEY;
      chk(dec_data_o == (plain_of(last_req_addr) ^ KEY), "R4 ciphertext to decryptor",
          dec_data_o, plain_of(last_req_addr) ^ KEY);
    end else if (dbusy) begin
      dcnt--;
      if (dcnt == 0) begin dec_done = 1'b1; dec_out = dbuf; dbusy = 1'b0; end
    end
  end

  task automatic write_tbl(input logic [5:0] idx, input logic [31:0] ch, input logic [6:0] off);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = idx; tbl_chunk = ch; tbl_off = off;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic do_miss(input logic [5:0] idx, input logic [31:0] ch, input logic [6:0] off,
                         input bit fetch, input bit bad, input string req);
    int m0, d0, n, line_cnt, line_n;
    logic [127:0] got_chunk;
    logic [6:0] got_off;
    bit ready_busy;
    m0 = mem_reqs; d0 = dec_starts; line_cnt = 0; line_n = 0; got_chunk = '0; got_off = '0;
    ready_busy = 1'b0;
    @(negedge clk);
    chk(miss_ready == 1'b1, {req, " R8 ready when idle"}, miss_ready, 1);
    miss_valid = 1'b1; miss_addr = 32'h4000_0000 | (32'(idx) << 4);
    @(posedge clk);
    @(negedge clk);
    miss_valid = 1'b0;
    n = 1;
    for (int k = 0; k < 200; k++) begin
      if (line_valid) begin line_cnt++; line_n = n; got_chunk = line_chunk; got_off = line_off; end
      if (!miss_ready && n == 1) ready_busy = 1'b1;
      if (miss_ready) break;
      @(negedge clk);
      n++;
    end
    chk(ready_busy, {req, " R8 ready low while busy"}, 0, 1);
    chk(mem_reqs - m0 == (fetch ? 1 : 0), {req, " R3/R6 memory requests"}, mem_reqs - m0, fetch ? 1 : 0);
    chk(dec_starts - d0 == (fetch ? 1 : 0), {req, " R4/R6 decrypt starts"}, dec_starts - d0, fetch ? 1 : 0);
    if (fetch) chk(last_req_addr == ch, {req, " R3 request address"}, last_req_addr, ch);
    if (bad) begin
      chk(line_cnt == 0, {req, " R7 no line on mismatch"}, line_cnt, 0);
      chk(int_err == 1'b1, {req, " R7 error flag"}, int_err, 1);
    end else begin
      chk(line_cnt == 1, {req, " R5 one line pulse"}, line_cnt, 1);
      chk(got_chunk == plain_of(ch), {req, " R5 chunk data"}, got_chunk, plain_of(ch));
      chk(got_off == off, {req, " R2/R5 offset"}, got_off, off);
      if (!fetch) chk(line_n == 1, {req, " R6 hit latency"}, line_n, 1);
      else chk(line_n >= 19, {req, " R5 fetch latency"}, line_n, 19);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(miss_ready == 1'b1, "R1 ready", miss_ready, 1);
    chk(mem_req == 1'b0, "R1 mem_req", mem_req, 0);
    chk(dec_start == 1'b0, "R1 dec_start", dec_start, 0);
    chk(line_valid == 1'b0, "R1 line_valid", line_valid, 0);
    chk(int_err == 1'b0, "R1 error", int_err, 0);

    write_tbl(6'd0, C0, 7'd32);
    write_tbl(6'd1, C0, 7'd74);
    write_tbl(6'd2, C1, 7'd40);
    write_tbl(6'd3, CSPL, 7'd32);
    write_tbl(6'd63, C3, 7'd100);

    do_miss(6'd0, C0, 7'd32, 1, 0, "R1 first miss fetches");
    do_miss(6'd1, C0, 7'd74, 0, 0, "R6 shared chunk hit");
    do_miss(6'd0, C0, 7'd32, 0, 0, "R6 repeat hit");
    do_miss(6'd63, C3, 7'd100, 1, 0, "R2 last index");
    do_miss(6'd2, C1, 7'd40, 1, 0, "R3 new chunk");
    do_miss(6'd3, CSPL, 7'd32, 1, 1, "R7 spliced chunk");
    do_miss(6'd2, C1, 7'd40, 1, 0, "R7 refetch after invalidate");
    chk(int_err == 1'b1, "R9 error stays set", int_err, 1);
    write_tbl(6'd1, C1, 7'd88);
    do_miss(6'd1, C1, 7'd88, 0, 0, "R2 rewritten entry");
    chk(int_err == 1'b1, "R9 error still set", int_err, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule